// File: doc/BRIEF.md
# Push-Pull Pulse-Steering PWM Controller

This block drives the two switches of a push-pull power stage from a clock. An internal period counter plays the part of a sawtooth ramp. A duty command word is compared against the ramp position measured after a fixed blanking gap. Each period yields at most one pulse, and a toggle stage sends successive periods to alternate outputs so the two sides are driven half a cycle apart. A period-start strobe marks every ramp restart.

Three inputs change the normal cycle. An external sync pulse restarts the ramp early, so the free-running period should be set roughly ten percent longer than the sync spacing. A current-limit flag cuts the present pulse short. A shutdown input holds both sides off. When shutdown ends, the steering stays frozen until the next period start, and the first pulse afterwards goes to the side that did not fire last. This protects the transformer core from two same-side pulses in a row.

Top module: `pushpull_pwm`

## Requirements
- R1: Out of reset the first pulse appears on `out_a`. In steady running, the side that carries the pulse flips at every period start, so pulses in consecutive periods appear on alternate outputs.
- R2: `out_a` and `out_b` are never high together. In the BLANK cycles that follow each `period_start` cycle, both are low.
- R3: Once a pulse ends inside a period, for whatever reason, neither output rises again until the next period start (at most one pulse per period).
- R4: While `shutdown` is high, both outputs are low from the next cycle on.
- R5: After `shutdown` falls, both outputs stay low until a `period_start` has occurred. The first pulse after that lands on the side opposite to the last pulse emitted before shutdown.
- R6: A `sync_in` pulse that stays high for at least two clock cycles restarts the ramp. With a periodic sync, the distance between `period_start` strobes equals the sync spacing.
- R7: A `sync_in` pulse only one cycle wide has no effect, and the period stays at `period`+1 cycles.
- R8: The pulse width in each period is min(`duty`, `period`+1-BLANK) cycles. A `duty` of 0 gives no pulse at all.
- R9: When `ilimit` is high, both outputs go low in the next cycle. The pulse then stays off for the rest of that period, even after `ilimit` drops.
- R10: During and directly after reset, `out_a`, `out_b` and `period_start` are low.
- R11: Without sync, `period_start` pulses for one cycle every `period`+1 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| duty | input | CNT_W | Pulse width command in clock cycles |
| period | input | CNT_W | Ramp terminal count; the period is this value plus one |
| sync_in | input | 1 | Asynchronous external ramp-restart pulse |
| shutdown | input | 1 | Holds both outputs off while high |
| ilimit | input | 1 | Current-limit flag; ends the present pulse |
| out_a | output | 1 | Drive for side A |
| out_b | output | 1 | Drive for side B |
| period_start | output | 1 | One-cycle strobe at each ramp restart |

## Verification
A steering flip-flop in the wrong state shows up in the very next period: the pulse lands on the same output as before. After shutdown this is a same-side double pulse, visible within one period of release. A stuck done-latch shows up within the same period as a second rising edge after a duty dip or a current-limit blip, or as a pulse that never starts. A counter or synchronizer fault changes the spacing of the `period_start` strobes, which a sync that should be ignored or obeyed exposes within one or two periods.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  function automatic side_e other_side(input side_e s);
    return (s == SIDE_A) ? SIDE_B : SIDE_A;
  endfunction
endpackage

// File: rtl/pwm_sync_detect.sv
// Synchronizes an asynchronous pulse and reports its rising edge only after
// it has stayed high for MIN_W synchronized samples.
module pwm_sync_detect #(
  parameter int STAGES = 2,
  parameter int MIN_W  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic hit
);
  localparam int LEN = STAGES + MIN_W;

  logic [LEN-1:0] shreg;
  logic [MIN_W-1:0] high_run;

  always_ff @(posedge clk) begin
    if (rst) shreg <= '0;
    else     shreg <= {shreg[LEN-2:0], pin};
  end

  for (genvar i = 0; i < MIN_W; i++) begin : g_run
    assign high_run[i] = shreg[STAGES-1+i];
  end

  assign hit = (&high_run) && !shreg[LEN-1];
endmodule

// File: rtl/pwm_ramp.sv
// Period counter acting as the ramp; restarts on wrap or on a sync hit.
module pwm_ramp #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] period,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt,
  output logic             start
);
  logic wrap;
  assign wrap = (cnt >= period);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      start <= 1'b0;
    end else begin
      cnt   <= (wrap || restart) ? '0 : cnt + 1'b1;
      start <= wrap || restart;
    end
  end
endmodule

// File: rtl/pwm_steer.sv
// Steering toggle, one-pulse latch, shutdown hold and registered drives.
module pwm_steer
  import pwm_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_window,
  input  logic start,
  input  logic shutdown,
  input  logic ilimit,
  output logic out_a,
  output logic out_b
);
  side_e sel, last;
  logic  hold, done, pulse_now, active;

  assign active    = out_a || out_b;
  assign pulse_now = in_window && !done && !hold && !shutdown && !ilimit;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel   <= SIDE_A;
      last  <= SIDE_B;
      hold  <= 1'b0;
      done  <= 1'b0;
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      hold <= shutdown || (hold && !start);
      if (start && !shutdown)
        sel <= hold ? other_side(last) : other_side(sel);
      done  <= start ? 1'b0 : (done || ilimit || (active && !pulse_now));
      out_a <= pulse_now && (sel == SIDE_A);
      out_b <= pulse_now && (sel == SIDE_B);
      if (out_a)      last <= SIDE_A;
      else if (out_b) last <= SIDE_B;
    end
  end
endmodule

// File: rtl/pushpull_pwm.sv
module pushpull_pwm #(
  parameter int CNT_W       = 8,
  parameter int BLANK       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SYNC_MIN_W  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] duty,
  input  logic [CNT_W-1:0] period,
  input  logic             sync_in,
  input  logic             shutdown,
  input  logic             ilimit,
  output logic             out_a,
  output logic             out_b,
  output logic             period_start
);
  localparam logic [CNT_W-1:0] BLANK_C = CNT_W'(BLANK);

  logic             sync_hit;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] ramp_pos;
  logic             in_window;

  pwm_sync_detect #(.STAGES(SYNC_STAGES), .MIN_W(SYNC_MIN_W)) u_sync (
    .clk(clk), .rst(rst), .pin(sync_in), .hit(sync_hit)
  );

  pwm_ramp #(.CNT_W(CNT_W)) u_ramp (
    .clk(clk), .rst(rst), .period(period), .restart(sync_hit),
    .cnt(cnt), .start(period_start)
  );

  assign ramp_pos  = cnt - BLANK_C;
  assign in_window = (cnt >= BLANK_C) && (ramp_pos < duty);

  pwm_steer u_steer (
    .clk(clk), .rst(rst), .in_window(in_window), .start(period_start),
    .shutdown(shutdown), .ilimit(ilimit), .out_a(out_a), .out_b(out_b)
  );
endmodule

// File: rtl/pushpull_pwm_chk.sv
module pushpull_pwm_chk (
  input logic clk,
  input logic rst,
  input logic shutdown,
  input logic ilimit,
  input logic out_a,
  input logic out_b,
  input logic period_start
);
  logic act, act_prev, start_prev, ended, hold_c, after_sd, last_b;
  assign act = out_a || out_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_prev <= 1'b0; start_prev <= 1'b0; ended <= 1'b0;
      hold_c <= 1'b0; after_sd <= 1'b0; last_b <= 1'b1;
    end else begin
      act_prev   <= act;
      start_prev <= period_start;
      ended      <= period_start ? 1'b0 : (ended || (act_prev && !act && !start_prev));
      hold_c     <= shutdown || (hold_c && !period_start);
      after_sd   <= shutdown ? 1'b1 : (act ? 1'b0 : after_sd);
      if (out_b)      last_b <= 1'b1;
      else if (out_a) last_b <= 1'b0;
    end
  end

  AST_NEVER_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b)); // R2
  AST_BLANK_AFTER_START: assert property (@(posedge clk) disable iff (rst)
    period_start |=> (!out_a && !out_b)); // R2
  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (ended && !period_start) |-> !act); // R3
  AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (rst)
    shutdown |=> (!out_a && !out_b)); // R4
  AST_HOLD_TO_TICK: assert property (@(posedge clk) disable iff (rst)
    hold_c |-> !act); // R5
  AST_RESUME_SIDE_A: assert property (@(posedge clk) disable iff (rst)
    (after_sd && $rose(out_a)) |-> last_b); // R5
  AST_RESUME_SIDE_B: assert property (@(posedge clk) disable iff (rst)
    (after_sd && $rose(out_b)) |-> !last_b); // R5
  AST_ILIMIT_OFF: assert property (@(posedge clk) disable iff (rst)
    ilimit |=> (!out_a && !out_b)); // R9
endmodule

bind pushpull_pwm pushpull_pwm_chk u_chk (
  .clk(clk), .rst(rst), .shutdown(shutdown), .ilimit(ilimit),
  .out_a(out_a), .out_b(out_b), .period_start(period_start)
);

// File: tb/pushpull_pwm_test.sv
`timescale 1ns/1ps
module pushpull_pwm_test;
  localparam int CNT_W = 8;
  localparam int BLANK = 2;
  localparam int PER   = 19;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0] duty = '0;
  logic [CNT_W-1:0] period = CNT_W'(PER);
  logic sync_in = 1'b0, shutdown = 1'b0, ilimit = 1'b0;
  logic out_a, out_b, period_start;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pushpull_pwm #(.CNT_W(CNT_W), .BLANK(BLANK)) uut (
    .clk(clk), .rst(rst), .duty(duty), .period(period), .sync_in(sync_in),
    .shutdown(shutdown), .ilimit(ilimit), .out_a(out_a), .out_b(out_b),
    .period_start(period_start)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One period window: from the cycle after a period_start strobe up to and
  // including the next one. kind 1 dips duty to 0, kind 2 pulses ilimit,
  // each for one cycle at sample number 'at'.
  task automatic run_window(input int kind, input int at,
                            output int wa, output int wb,
                            output int edges, output int len);
    logic [CNT_W-1:0] saved;
    bit prev;
    saved = duty;
    wa = 0; wb = 0; edges = 0; len = 0; prev = 1'b0;
    while (!period_start) @(negedge clk);
    do begin
      @(negedge clk);
      len++;
      if (out_a) wa++;
      if (out_b) wb++;
      if ((out_a || out_b) && !prev) edges++;
      prev = out_a || out_b;
      if (len == at) begin
        if (kind == 1) duty = '0;
        if (kind == 2) ilimit = 1'b1;
      end
      if (len == at + 1) begin
        if (kind == 1) duty = saved;
        if (kind == 2) ilimit = 1'b0;
      end
    end while (!period_start);
  endtask

  task automatic t_reset();
    int wa = 0, wb = 0, len = 0;
    duty = 8'd5;
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check(!out_a && !out_b && !period_start, "R10", "outputs in reset",
          {out_a, out_b, period_start}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(!out_a && !out_b && !period_start, "R10", "outputs after reset",
          {out_a, out_b, period_start}, 0);
    len = 1;
    while (!period_start) begin
      @(negedge clk);
      len++;
      if (out_a) wa++;
      if (out_b) wb++;
    end
    check(wa == 5, "R1", "first pulse width on out_a", wa, 5);
    check(wb == 0, "R1", "no pulse on out_b first", wb, 0);
    check(len == PER + 1, "R11", "first period length", len, PER + 1);
  endtask

  task automatic t_alternate();
    int wa, wb, e, len;
    bit prev_a = 1'b1;  // first window after reset tick goes to out_b
    duty = 8'd5;
    for (int i = 0; i < 4; i++) begin
      run_window(0, 0, wa, wb, e, len);
      check((wa > 0) != prev_a, "R1", "side alternates", wa, wb);
      check(wa + wb == 5, "R8", "width duty 5", wa + wb, 5);
      check(len == PER + 1, "R11", "free-run period", len, PER + 1);
      prev_a = (wa > 0);
    end
  endtask

  task automatic t_duty_range();
    int wa, wb, e, len;
    duty = '0;
    run_window(0, 0, wa, wb, e, len);
    check(wa + wb == 0, "R8", "duty 0 gives no pulse", wa + wb, 0);
    duty = 8'd255;
    run_window(0, 0, wa, wb, e, len);
    check(wa + wb == PER + 1 - BLANK, "R8", "duty capped", wa + wb, PER + 1 - BLANK);
    check(e == 1, "R3", "single pulse at cap", e, 1);
    duty = 8'd18;
    run_window(0, 0, wa, wb, e, len);
    check(wa + wb == 18, "R8", "duty at cap edge", wa + wb, 18);
    duty = 8'd7;
    run_window(0, 0, wa, wb, e, len);
    check(wa + wb == 7, "R8", "duty 7", wa + wb, 7);
  endtask

  task automatic t_latch_glitch();
    int wa, wb, e, len;
    duty = 8'd8;
    run_window(1, 5, wa, wb, e, len);
    check(e == 1, "R3", "no restart after duty dip", e, 1);
    check(wa + wb == 3, "R3", "width cut by duty dip", wa + wb, 3);
  endtask

  task automatic t_ilimit();
    int wa, wb, e, len;
    duty = 8'd8;
    run_window(2, 5, wa, wb, e, len);
    check(e == 1, "R9", "no restart after ilimit", e, 1);
    check(wa + wb == 3, "R9", "width cut by ilimit", wa + wb, 3);
    run_window(0, 0, wa, wb, e, len);
    check(wa + wb == 8, "R9", "next period full width", wa + wb, 8);
  endtask

  task automatic t_shutdown();
    int wa, wb, e, len, sum;
    bit last_a;
    duty = 8'd5;
    run_window(0, 0, wa, wb, e, len);
    last_a = (wa > 0);
    shutdown = 1'b1;
    for (int i = 0; i < 2; i++) begin
      run_window(0, 0, wa, wb, e, len);
      check(wa + wb == 0, "R4", "outputs off in shutdown", wa + wb, 0);
    end
    repeat (5) @(negedge clk);
    shutdown = 1'b0;
    sum = 0;
    while (!period_start) begin
      @(negedge clk);
      if (out_a || out_b) sum++;
    end
    check(sum == 0, "R5", "no pulse before first tick", sum, 0);
    run_window(0, 0, wa, wb, e, len);
    check((wa > 0) != last_a && (wa + wb == 5), "R5", "resume on opposite side",
          wa, last_a ? 0 : 5);
  endtask

  task automatic t_sync();
    int wa, wb, e, len;
    int lens[4];
    duty = 8'd5;
    while (!period_start) @(negedge clk);
    fork
      begin
        for (int k = 0; k < 8; k++) begin
          sync_in = 1'b1;
          repeat (3) @(negedge clk);
          sync_in = 1'b0;
          repeat (12) @(negedge clk);
        end
      end
      begin
        for (int k = 0; k < 4; k++) begin
          run_window(0, 0, wa, wb, e, len);
          lens[k] = len;
        end
      end
    join
    check(lens[2] == 15, "R6", "sync period", lens[2], 15);
    check(lens[3] == 15, "R6", "sync period", lens[3], 15);
  endtask

  task automatic t_sync_short();
    int wa, wb, e, len;
    int lens[2];
    while (!period_start) @(negedge clk);
    fork
      begin
        for (int k = 0; k < 9; k++) begin
          sync_in = 1'b1;
          @(negedge clk);
          sync_in = 1'b0;
          repeat (6) @(negedge clk);
        end
      end
      begin
        for (int k = 0; k < 2; k++) begin
          run_window(0, 0, wa, wb, e, len);
          lens[k] = len;
        end
      end
    join
    check(lens[0] == PER + 1, "R7", "short sync ignored", lens[0], PER + 1);
    check(lens[1] == PER + 1, "R7", "short sync ignored", lens[1], PER + 1);
  endtask

  initial begin
    for (int c = 0; c < 50000 && !finished; c++) @(negedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_alternate();
    t_duty_range();
    t_latch_glitch();
    t_ilimit();
    t_shutdown();
    t_sync();
    t_sync_short();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule